// File: doc/BRIEF.md
# Wide-Frame SPI Master

This block is a memory-mapped serial peripheral interface master. Its 128-bit shift vector is exposed as four 32-bit data words. Software fills the words, sets the frame length, and picks the serial clock edge that launches MOSI and, separately, the edge that samples MISO. It then writes the start bit. The engine shifts the frame MSB-first. Each received bit replaces the transmitted bits in place, so once the frame is done the same four words hold the reply.

The serial clock rate is the system clock divided by 2×(D+1), where D is the divider register. The busy flag is the start bit read back, so software polls it. A slave-select register drives the select lines directly, one bit per line, and can be written at any time. Configuration, divider and data registers are frozen while a frame is in flight.

Top module: `spiw_master`

## Requirements
- R1: After a synchronous reset the following all read as zero: the data words, the control register, the divider and the select register. All `ss_n` lines are high (deasserted), and `sclk` and `mosi` are low.
- R2: The word addresses are data word w (w = 0..3, vector bits 32w+31..32w) at byte offset 4w, control at 0x10, divider at 0x14 and select at 0x18. Control bits [7:0] hold the frame length L. Bit 8 is start/busy, bit 9 selects launch on the falling edge (0 = rising), and bit 10 selects sample on the falling edge (0 = rising). Unused control bits, divider bits above 15, select bits above the line count, and the unmapped offset 0x1C all read as zero.
- R3: Every register write honours the four byte enables. Byte b covers write-data bits 8b+7..8b.
- R4: Writing 1 to bit 8 while idle starts a frame. Bit 8 then reads 1 for exactly 2·L·(D+1) system clocks and clears by itself.
- R5: `sclk` is low whenever no frame runs. Each frame gives L high pulses of D+1 system clocks each, starting with a rising edge.
- R6: Wire bit k (k = 0 first) is vector bit L−1−k, so with L = 128 the top bit of data word 3 goes first. When launch and sample use opposite edges, the MOSI level just before sample edge k equals vector bit L−1−k.
- R7: After a frame, vector bits L−1..0 hold the MISO values taken at the sample edges, with the first sample in bit L−1. Vector bits above L−1 are unchanged.
- R8: A length field of 0, or any value above 128, gives a 128-bit frame.
- R9: MOSI changes only when a frame starts or on an edge of the selected launch polarity. The sample polarity chooses which edges capture MISO, and all four combinations work.
- R10: While busy, writes to the control, divider and data registers are ignored.
- R11: Select bit n drives `ss_n[n]` low one clock after the write, even in the middle of a frame.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | System clock |
| rst | input | 1 | Synchronous active-high reset |
| bus_sel | input | 1 | Register access strobe |
| bus_we | input | 1 | Write when 1, read otherwise |
| bus_addr | input | 3 | Word address (byte offset bits 4..2) |
| bus_wdata | input | 32 | Write data |
| bus_be | input | 4 | Byte enables |
| bus_rdata | output | 32 | Combinational read data of the addressed word |
| sclk | output | 1 | Serial clock, idles low |
| mosi | output | 1 | Serial data out |
| miso | input | 1 | Serial data in |
| ss_n | output | SS_W (8) | Active-low slave selects |

## Verification
The embedded properties check the following on every cycle: the serial clock idles low, the divider count stays within its bound, busy persists until the final edge, MOSI holds still between launch edges, the configuration stays frozen while busy, and select writes reach the pins. Other behaviours can only be shown by the bench's scenarios, because they need a whole frame against a slave model. These are bit order across all four polarity pairings, the in-place merge of the reply above and below the frame length, the exact busy duration, the pulse width and count, the treatment of length 0 and of lengths over 128, byte-enable merging, and writes ignored in the middle of a frame.

// File: rtl/spiw_pkg.sv
package spiw_pkg;
    localparam int WORD_W  = 32;
    localparam int NWORDS  = 4;
    localparam int NBYTES  = WORD_W / 8;
    localparam int FRAME_W = WORD_W * NWORDS;
    localparam int IDX_W   = $clog2(FRAME_W);
    localparam int LEN_W   = IDX_W + 1;
    localparam int CNT_W   = LEN_W + 2;
    localparam int ADDR_W  = 5;

    localparam logic [2:0] IDX_CTRL = 3'd4;
    localparam logic [2:0] IDX_DIV  = 3'd5;
    localparam logic [2:0] IDX_SS   = 3'd6;

    localparam int BIT_GO  = 8;
    localparam int BIT_TXF = 9;
    localparam int BIT_RXF = 10;

    typedef struct packed {
        logic             rx_fall;
        logic             tx_fall;
        logic [LEN_W-1:0] len;
    } cfg_t;

    function automatic logic [LEN_W:0] frame_bits(input logic [LEN_W-1:0] len);
        if (len == '0 || int'(len) > FRAME_W) return (LEN_W+1)'(FRAME_W);
        return {1'b0, len};
    endfunction

    function automatic logic [WORD_W-1:0] merge_bytes(input logic [WORD_W-1:0] old_w,
                                                     input logic [WORD_W-1:0] new_w,
                                                     input logic [NBYTES-1:0] be);
        logic [WORD_W-1:0] r;
        r = old_w;
        for (int b = 0; b < NBYTES; b++)
            if (be[b]) r[8*b +: 8] = new_w[8*b +: 8];
        return r;
    endfunction
endpackage

// File: rtl/spiw_clkdiv.sv
module spiw_clkdiv #(
    parameter int DIV_W = 16
) (
    input  logic             clk,
    input  logic             rst,
    input  logic             run,
    input  logic [DIV_W-1:0] div,
    output logic             tick
);
    logic [DIV_W-1:0] cnt;

    always_ff @(posedge clk) begin
        if (rst || !run)      cnt <= '0;
        else if (cnt == div)  cnt <= '0;
        else                  cnt <= cnt + 1'b1;
    end

    assign tick = run && (cnt == div);

    p_cnt_bound_r5: assert property (@(posedge clk) disable iff (rst)
        run |-> cnt <= div);
endmodule

// File: rtl/spiw_engine.sv
module spiw_engine
    import spiw_pkg::*;
(
    input  logic                clk,
    input  logic                rst,
    input  logic                start,
    input  cfg_t                cfg,
    input  logic [LEN_W:0]      start_bits,
    input  logic                tick,
    input  logic                miso,
    input  logic [NWORDS-1:0]   wr_word,
    input  logic [NBYTES-1:0]   wr_be,
    input  logic [WORD_W-1:0]   wr_data,
    output logic [FRAME_W-1:0]  vec,
    output logic                busy,
    output logic                sclk,
    output logic                mosi
);
    logic [LEN_W:0]       nbits;
    logic [CNT_W-1:0]     edge_cnt, last_edge;
    logic [FRAME_W-1:0]   mask, shifted;
    logic                 rise_now, fall_now, launch, sample, top_bit, start_bit;

    assign nbits     = frame_bits(cfg.len);
    assign last_edge = CNT_W'({nbits, 1'b0}) - 1'b1;
    assign rise_now  = tick && !sclk;
    assign fall_now  = tick && sclk;
    assign launch    = cfg.tx_fall ? fall_now : rise_now;
    assign sample    = cfg.rx_fall ? fall_now : rise_now;
    assign top_bit   = vec[IDX_W'(nbits - 1'b1)];
    assign start_bit = vec[IDX_W'(start_bits - 1'b1)];
    assign mask      = (int'(nbits) >= FRAME_W) ? '1
                     : ((FRAME_W'(1) << nbits) - FRAME_W'(1));
    assign shifted   = {vec[FRAME_W-2:0], miso};

    always_ff @(posedge clk) begin
        if (rst) begin
            vec      <= '0;
            busy     <= 1'b0;
            sclk     <= 1'b0;
            mosi     <= 1'b0;
            edge_cnt <= '0;
        end else if (start) begin
            busy     <= 1'b1;
            sclk     <= 1'b0;
            edge_cnt <= '0;
            mosi     <= start_bit;
        end else if (busy) begin
            if (tick) begin
                sclk     <= ~sclk;
                edge_cnt <= edge_cnt + 1'b1;
                if (launch) mosi <= top_bit;
                if (sample) vec  <= (vec & ~mask) | (shifted & mask);
                if (edge_cnt == last_edge) busy <= 1'b0;
            end
        end else begin
            for (int w = 0; w < NWORDS; w++)
                if (wr_word[w])
                    vec[w*WORD_W +: WORD_W] <= merge_bytes(vec[w*WORD_W +: WORD_W], wr_data, wr_be);
        end
    end

    p_sclk_idle_r5: assert property (@(posedge clk) disable iff (rst)
        !busy |-> !sclk);
    p_busy_hold_r4: assert property (@(posedge clk) disable iff (rst)
        busy && !(tick && edge_cnt == last_edge) |=> busy);
    p_edge_bound_r4: assert property (@(posedge clk) disable iff (rst)
        busy |-> edge_cnt <= last_edge);
    p_mosi_launch_r9: assert property (@(posedge clk) disable iff (rst)
        busy && $past(busy) && !$past(launch) |-> $stable(mosi));
endmodule

// File: rtl/spiw_master.sv
module spiw_master
    import spiw_pkg::*;
#(
    parameter int DIV_W = 16,
    parameter int SS_W  = 8
) (
    input  logic                clk,
    input  logic                rst,
    input  logic                bus_sel,
    input  logic                bus_we,
    input  logic [ADDR_W-1:2]   bus_addr,
    input  logic [WORD_W-1:0]   bus_wdata,
    input  logic [NBYTES-1:0]   bus_be,
    output logic [WORD_W-1:0]   bus_rdata,
    output logic                sclk,
    output logic                mosi,
    input  logic                miso,
    output logic [SS_W-1:0]     ss_n
);
    cfg_t                cfg_q, cfg_next;
    logic [DIV_W-1:0]    div_q;
    logic [SS_W-1:0]     ss_q;
    logic                busy, tick, wr, open_wr, ctrl_wr, start;
    logic [NWORDS-1:0]   wr_word;
    logic [FRAME_W-1:0]  vec;

    assign wr      = bus_sel && bus_we;
    assign open_wr = wr && !busy;
    assign ctrl_wr = open_wr && (bus_addr == IDX_CTRL);

    always_comb begin
        cfg_next         = cfg_q;
        if (bus_be[0]) cfg_next.len = bus_wdata[LEN_W-1:0];
        if (bus_be[1]) begin
            cfg_next.tx_fall = bus_wdata[BIT_TXF];
            cfg_next.rx_fall = bus_wdata[BIT_RXF];
        end
    end
    assign start = ctrl_wr && bus_be[1] && bus_wdata[BIT_GO];

    generate
        for (genvar w = 0; w < NWORDS; w++) begin : g_wsel
            assign wr_word[w] = open_wr && (bus_addr == 3'(w));
        end
    endgenerate

    always_ff @(posedge clk) begin
        if (rst) begin
            cfg_q <= '0;
            div_q <= '0;
            ss_q  <= '0;
        end else begin
            if (ctrl_wr) cfg_q <= cfg_next;
            if (open_wr && bus_addr == IDX_DIV)
                div_q <= DIV_W'(merge_bytes(WORD_W'(div_q), bus_wdata, bus_be));
            if (wr && bus_addr == IDX_SS)
                ss_q <= SS_W'(merge_bytes(WORD_W'(ss_q), bus_wdata, bus_be));
        end
    end

    assign ss_n = ~ss_q;

    always_comb begin
        bus_rdata = '0;
        if (int'(bus_addr) < NWORDS)
            bus_rdata = vec[int'(bus_addr)*WORD_W +: WORD_W];
        else if (bus_addr == IDX_CTRL)
            bus_rdata = WORD_W'({cfg_q.rx_fall, cfg_q.tx_fall, busy, cfg_q.len});
        else if (bus_addr == IDX_DIV)
            bus_rdata = WORD_W'(div_q);
        else if (bus_addr == IDX_SS)
            bus_rdata = WORD_W'(ss_q);
    end

    spiw_clkdiv #(.DIV_W(DIV_W)) u_div (
        .clk(clk), .rst(rst), .run(busy), .div(div_q), .tick(tick)
    );

    spiw_engine u_eng (
        .clk(clk), .rst(rst), .start(start), .cfg(cfg_q),
        .start_bits(frame_bits(cfg_next.len)), .tick(tick), .miso(miso),
        .wr_word(wr_word), .wr_be(bus_be), .wr_data(bus_wdata),
        .vec(vec), .busy(busy), .sclk(sclk), .mosi(mosi)
    );

    p_cfg_frozen_r10: assert property (@(posedge clk) disable iff (rst)
        busy && $past(busy) |-> $stable(cfg_q) && $stable(div_q));
    p_start_busy_r4: assert property (@(posedge clk) disable iff (rst)
        start |=> busy);
    p_ss_follow_r11: assert property (@(posedge clk) disable iff (rst)
        wr && bus_addr == IDX_SS && bus_be == '1 |=> ss_n == ~$past(bus_wdata[SS_W-1:0]));
endmodule

// File: tb/sim_spiw_master.sv
module sim_spiw_master;
    logic         clk = 1'b0;
    logic         rst = 1'b1;
    logic         bus_sel = 1'b0, bus_we = 1'b0;
    logic [4:2]   bus_addr = '0;
    logic [31:0]  bus_wdata = '0;
    logic [3:0]   bus_be = '0;
    logic [31:0]  bus_rdata;
    logic         sclk, mosi;
    logic         miso = 1'b0;
    logic [7:0]   ss_n;

    always #4 clk = ~clk;

    spiw_master u0 (.*);

    int errors = 0, checks = 0;
    bit done = 0;

    typedef struct packed {
        logic [7:0]   len;
        logic [15:0]  dv;
        logic         txf;
        logic         rxf;
        logic [127:0] tx;
        logic [127:0] rx;
    } vec_t;

    localparam vec_t TAB [7] = '{
        '{8'd8,   16'd1, 1'b1, 1'b0, 128'h0123_4567_89AB_CDEF_FEDC_BA98_7654_32A5, 128'hFFFF_0000_1111_2222_3333_4444_5555_663C},
        '{8'd32,  16'd0, 1'b0, 1'b1, 128'hDEAD_BEEF_0BAD_F00D_CAFE_BABE_8001_7FFE, 128'h1357_9BDF_2468_ACE0_0F0F_F0F0_A5C3_3C5A},
        '{8'd0,   16'd0, 1'b1, 1'b0, 128'h8000_0000_1234_5678_9ABC_DEF0_0000_0001, 128'hC3A5_5A3C_9696_6969_F00F_0FF0_1248_8421},
        '{8'd13,  16'd2, 1'b1, 1'b1, 128'h0000_0000_0000_0000_0000_0000_0000_1ABC, 128'hFFFF_FFFF_FFFF_FFFF_FFFF_FFFF_FFFF_E555},
        '{8'd128, 16'd0, 1'b0, 1'b0, 128'h5555_AAAA_3333_CCCC_0F0F_F0F0_00FF_FF00, 128'h0123_4567_89AB_CDEF_0123_4567_89AB_CDEF},
        '{8'd1,   16'd3, 1'b0, 1'b1, 128'h1111_2222_3333_4444_5555_6666_7777_8880, 128'h0000_0000_0000_0000_0000_0000_0000_0001},
        '{8'd200, 16'd0, 1'b1, 1'b0, 128'hF0E1_D2C3_B4A5_9687_7869_5A4B_3C2D_1E0F, 128'h0F1E_2D3C_4B5A_6978_8796_A5B4_C3D2_E1F0}
    };

    // slave model / monitor state
    bit           mon_active = 0;
    int           mon_len = 1, mon_k = 0, mon_rises = 0, mon_hi_run = 0, mon_hi_bad = 0;
    int           mon_div = 0;
    logic         mon_rxf = 0;
    logic [127:0] mon_rx = '0, mon_cap = '0;
    logic         prev_sclk = 0, prev_mosi = 0;

    task automatic check(input bit ok, input string tag, input logic [127:0] act, input logic [127:0] exp);
        checks++;
        if (!ok) begin
            errors++;
            $display("FAIL %s actual=%h expected=%h", tag, act, exp);
        end
    endtask

    task automatic bus_write(input logic [4:0] a, input logic [31:0] d, input logic [3:0] be);
        @(negedge clk);
        bus_sel = 1'b1; bus_we = 1'b1; bus_addr = a[4:2]; bus_wdata = d; bus_be = be;
        @(negedge clk);
        bus_sel = 1'b0; bus_we = 1'b0;
    endtask

    task automatic bus_read(input logic [4:0] a, output logic [31:0] d);
        bus_addr = a[4:2];
        #1;
        d = bus_rdata;
    endtask

    initial begin
        forever begin
            @(negedge clk);
            if (mon_active) begin
                if (sclk != prev_sclk) begin
                    if (sclk) mon_rises++;
                    if (mon_rxf ? !sclk : sclk) begin
                        if (mon_k < mon_len) mon_cap[mon_len-1-mon_k] = prev_mosi;
                        mon_k++;
                        if (mon_k < mon_len) miso = mon_rx[mon_len-1-mon_k];
                    end
                end
                if (sclk) mon_hi_run++;
                else if (prev_sclk) begin
                    if (mon_hi_run != mon_div + 1) mon_hi_bad++;
                    mon_hi_run = 0;
                end
            end
            prev_sclk = sclk;
            prev_mosi = mosi;
        end
    end

    task automatic run_frame(input logic [7:0] len_f, input logic [15:0] dv, input logic txf,
                             input logic rxf, input logic [127:0] tx, input logic [127:0] rx,
                             input bit inject);
        int L, cyc;
        logic [127:0] msk, exp;
        logic [31:0] rd;
        L   = (len_f == 0 || len_f > 128) ? 128 : int'(len_f);
        msk = (L == 128) ? '1 : ((128'd1 << L) - 128'd1);
        exp = (tx & ~msk) | (rx & msk);
        for (int w = 0; w < 4; w++) bus_write(5'(4*w), tx[32*w +: 32], 4'hF);
        bus_write(5'h14, {16'h0, dv}, 4'hF);
        mon_len = L; mon_rxf = rxf; mon_rx = rx; mon_k = 0; mon_rises = 0;
        mon_hi_run = 0; mon_hi_bad = 0; mon_div = int'(dv); mon_cap = '0;
        miso = rx[L-1];
        mon_active = 1;
        bus_write(5'h10, {21'b0, rxf, txf, 1'b1, len_f}, 4'hF);
        if (inject) begin
            bus_write(5'h14, 32'h7, 4'hF);
            bus_write(5'h00, 32'hFFFF_FFFF, 4'hF);
            bus_write(5'h10, 32'h0000_0005, 4'hF);
            bus_write(5'h18, 32'h0000_0005, 4'hF);
            check(ss_n == 8'hFA, "R11 select write mid-frame", 128'(ss_n), 128'hFA);
            bus_read(5'h10, rd);
            check(rd[8] == 1'b1 && rd[7:0] == len_f, "R10 ctrl write ignored while busy",
                  128'(rd), 128'({1'b1, len_f}));
        end
        cyc = 0;
        bus_read(5'h10, rd);
        while (rd[8] && cyc < 100000) begin
            cyc++;
            @(negedge clk);
            bus_read(5'h10, rd);
        end
        mon_active = 0;
        if (!inject)
            check(cyc == 2*L*(int'(dv)+1), "R4 busy duration", 128'(cyc), 128'(2*L*(int'(dv)+1)));
        check(mon_rises == L, "R5 sclk pulse count", 128'(mon_rises), 128'(L));
        check(mon_hi_bad == 0, "R5 sclk high width", 128'(mon_hi_bad), 128'd0);
        check(sclk == 1'b0, "R5 sclk idle low after frame", 128'(sclk), 128'd0);
        if (txf != rxf)
            check((mon_cap & msk) == (tx & msk), "R6 R9 mosi bit order", mon_cap & msk, tx & msk);
        for (int w = 0; w < 4; w++) begin
            bus_read(5'(4*w), rd);
            check(rd == exp[32*w +: 32], "R7 R9 received data in place", 128'(rd), 128'(exp[32*w +: 32]));
        end
        if (inject) begin
            bus_read(5'h14, rd);
            check(rd == {16'h0, dv}, "R10 divider write ignored while busy", 128'(rd), 128'(dv));
        end
    endtask

    initial begin
        repeat (200000) @(posedge clk);
        if (!done) begin
            errors++; checks++;
            $display("FAIL watchdog expired");
            $display("Result: errors=%0d of %0d checks", errors, checks);
            $finish;
        end
    end

    initial begin
        logic [31:0] rd;
        repeat (4) @(negedge clk);
        rst = 1'b0;
        @(negedge clk);

        // R1 reset state
        for (int a = 0; a < 7; a++) begin
            bus_read(5'(4*a), rd);
            check(rd == 32'h0, "R1 register reset value", 128'(rd), 128'd0);
        end
        check(ss_n == 8'hFF && sclk == 1'b0 && mosi == 1'b0, "R1 pins at reset",
              128'({ss_n, sclk, mosi}), 128'({8'hFF, 2'b00}));

        // main table walk (R4 R5 R6 R7 R8 R9)
        for (int i = 0; i < 7; i++)
            run_frame(TAB[i].len, TAB[i].dv, TAB[i].txf, TAB[i].rxf, TAB[i].tx, TAB[i].rx, 1'b0);

        // R8: length 0 and over 128 both give a full frame; first bit is top of word 3
        run_frame(8'd0, 16'd0, 1'b1, 1'b0, {1'b1, 127'h0}, 128'h0, 1'b0);
        check(mon_cap[127] == 1'b1, "R8 R6 word 3 bit 31 sent first", 128'(mon_cap[127]), 128'd1);

        // R10 R11 writes during a frame
        run_frame(8'd16, 16'd3, 1'b0, 1'b1, 128'h0000_0000_0000_0000_0000_0000_0000_C0DE,
                  128'h0000_0000_0000_0000_0000_0000_0000_BEEF, 1'b1);

        // R3 byte enables
        bus_write(5'h04, 32'h0, 4'hF);
        bus_write(5'h04, 32'hAABB_CCDD, 4'b0101);
        bus_read(5'h04, rd);
        check(rd == 32'h00BB_00DD, "R3 data byte enables", 128'(rd), 128'h00BB_00DD);
        bus_write(5'h14, 32'h0000_1234, 4'b0001);
        bus_read(5'h14, rd);
        check(rd == 32'h0000_0034, "R3 divider byte enables", 128'(rd), 128'h34);

        // R2 reserved and unmapped bits
        bus_write(5'h10, 32'hFFFF_FEFF, 4'hF);
        bus_read(5'h10, rd);
        check(rd == 32'h0000_06FF, "R2 control readback", 128'(rd), 128'h6FF);
        bus_write(5'h14, 32'hFFFF_FFFF, 4'hF);
        bus_read(5'h14, rd);
        check(rd == 32'h0000_FFFF, "R2 divider width", 128'(rd), 128'hFFFF);
        bus_write(5'h18, 32'hFFFF_FFFF, 4'hF);
        bus_read(5'h18, rd);
        check(rd == 32'h0000_00FF && ss_n == 8'h00, "R2 R11 select width", 128'(rd), 128'hFF);
        bus_write(5'h18, 32'h0000_0000, 4'hF);
        check(ss_n == 8'hFF, "R11 select release", 128'(ss_n), 128'hFF);
        bus_read(5'h1C, rd);
        check(rd == 32'h0, "R2 unmapped offset", 128'(rd), 128'd0);

        done = 1;
        $display("Result: errors=%0d of %0d checks", errors, checks);
        $finish;
    end
endmodule